// File: doc/BRIEF.md
# FIFO Occupancy Threshold Flag Unit

This block keeps the occupancy count of a single-clock FIFO of parameterised depth and derives five status flags from it: full, empty, half-full, almost-empty and almost-full. The storage array sits outside the block. The block sees only the push and pop requests and reports the resulting fill level.

The two almost flags compare the fill level against two programmable offsets. One offset is measured up from empty and the other down from full. A master reset loads both offsets from one of eight built-in pairs, chosen by a select input. After that, software can overwrite them through a parallel word port or a one-bit serial port. Both ports share one write sequence, which alternates between the empty-side offset and the full-side offset. A separate read sequence returns the offsets on a readback output.

A timing-select input is captured during master reset. It decides whether the almost flags are registered, and so lag by one clock, or follow the level directly. A partial reset empties the FIFO and restarts both sequences without touching the programmed offsets.

Top module: `thr_flag_unit`

## Requirements
- R1: A push is accepted only while not full and a pop only while not empty. When both are accepted in the same cycle, `level` is unchanged. Otherwise `level` moves by one on the next clock edge.
- R2: `full` is high exactly when `level` equals DEPTH, and `empty` is high exactly when `level` is 0.
- R3: `half` is high exactly when `level` is greater than DEPTH/2.
- R4: The almost-empty condition is `level` <= empty offset. The almost-full condition is DEPTH - `level` <= full offset. With `mode_sel`=1 captured at master reset, the almost flags show these conditions for the current level and offsets. With `mode_sel`=0 they show the conditions as they stood one clock earlier.
- R5: While `rst_n` is low at a clock edge, the level is cleared, `mode_sel` is captured, and preset k = `preset_sel` loads an empty offset of k+1 and a full offset of 2k+1 (truncated to OFFW bits). `preset_sel` and `mode_sel` have no effect outside master reset.
- R6: `par_ld` writes `par_din` into the offset chosen by the write sequence, starting with the empty offset and then alternating. The new value takes effect on the next clock edge.
- R7: With `ser_en` high, one bit of `ser_din` is taken per clock, least significant bit first. After OFFW bits the assembled value is written to the offset chosen by the same write sequence, and the sequence advances.
- R8: When `par_ld` and `ser_en` are high in the same cycle, the parallel write takes place and that serial bit is discarded.
- R9: `cfg_rd` loads `cfg_q` on the next edge with the offset chosen by a read sequence. The read sequence starts at the empty offset and alternates on each read.
- R10: A low `prst_n` at a clock edge (with `rst_n` high) clears the level, the write sequence, the read sequence and any partly received serial value, and keeps both offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| prst_n | input | 1 | Synchronous active-low partial reset |
| preset_sel | input | 3 | Preset offset pair index, used during master reset |
| mode_sel | input | 1 | Almost-flag timing, 1 = direct, 0 = registered; used during master reset |
| push | input | 1 | Write request |
| pop | input | 1 | Read request |
| par_ld | input | 1 | Parallel offset write strobe |
| par_din | input | OFFW | Parallel offset value |
| ser_en | input | 1 | Serial bit valid |
| ser_din | input | 1 | Serial offset bit |
| cfg_rd | input | 1 | Offset readback strobe |
| cfg_q | output | OFFW | Offset readback value |
| level | output | LW | Current occupancy |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| half | output | 1 | Occupancy above DEPTH/2 |
| almost_empty | output | 1 | Empty-side threshold flag |
| almost_full | output | 1 | Full-side threshold flag |

## Verification
Two pairs of functions can land in the same cycle. The first is a push and a pop. The bench provokes it at every level on the way up, including at full, where only the pop may be accepted. It judges the result against an arithmetic occupancy model through `level` and all five flags. The second is a parallel write and a serial bit. The bench starts a serial word, interleaves one parallel write, finishes the serial word, and reads both offsets back. It judges the values by the rule that the parallel write wins, the serial bit is dropped, and the serial word lands in the other offset.

// File: rtl/thr_pkg.sv
// Package thr_pkg
// Shared types and preset table arithmetic for the threshold flag unit.
// Assumes offsets are at most 32 bits wide.
package thr_pkg;

    // Which offset register a sequence currently points at
    typedef enum logic {
        OFF_EMPTY = 1'b0,
        OFF_FULL  = 1'b1
    } off_sel_e;

    // Preset empty-side offset for index k: k+1
    function automatic int unsigned preset_empty(input logic [2:0] k);
        return int'(k) + 1;
    endfunction

    // Preset full-side offset for index k: 2k+1
    function automatic int unsigned preset_full(input logic [2:0] k);
        return 2 * int'(k) + 1;
    endfunction

endpackage

// File: rtl/occ_counter.sv
// Module occ_counter
// Tracks the FIFO fill level from push/pop requests and reports full/empty.
// Assumes a single clock; a push at full and a pop at empty are refused.
module occ_counter #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prst_n,
    input  logic          push,
    input  logic          pop,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic do_push;
    logic do_pop;

    // Qualify requests against the current boundaries
    always_comb begin
        full    = (level == LW'(DEPTH));
        empty   = (level == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // Update the fill level by at most one per cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n) begin
            level <= '0;
        end else if (do_push && !do_pop) begin
            level <= level + 1'b1;
        end else if (do_pop && !do_push) begin
            level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/offset_regs.sv
// Module offset_regs
// Holds the two threshold offsets, loads presets at master reset, accepts
// parallel and LSB-first serial writes through one alternating write
// sequence, and returns values through an alternating read sequence.
// Assumes OFFW >= 2; a parallel write takes precedence over a serial bit.
module offset_regs
    import thr_pkg::*;
#(
    parameter int OFFW = 4,
    parameter int BCW  = $clog2(OFFW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prst_n,
    input  logic [2:0]      preset_sel,
    input  logic            par_ld,
    input  logic [OFFW-1:0] par_din,
    input  logic            ser_en,
    input  logic            ser_din,
    input  logic            cfg_rd,
    output logic [OFFW-1:0] ae_off,
    output logic [OFFW-1:0] af_off,
    output logic [OFFW-1:0] cfg_q
);
    logic [OFFW-1:0] off_q [2];
    off_sel_e        wr_sel;
    off_sel_e        rd_sel;
    logic [BCW-1:0]  bit_cnt;
    logic [OFFW-2:0] sh_q;
    logic            ser_last;

    assign ae_off   = off_q[OFF_EMPTY];
    assign af_off   = off_q[OFF_FULL];
    assign ser_last = (bit_cnt == BCW'(OFFW - 1));

    // Offset storage: presets at master reset, then parallel or serial writes
    generate
        for (genvar i = 0; i < 2; i++) begin : g_off
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    off_q[i] <= (i == 0) ? OFFW'(preset_empty(preset_sel))
                                         : OFFW'(preset_full(preset_sel));
                end else if (prst_n && (wr_sel == off_sel_e'(i))) begin
                    if (par_ld) begin
                        off_q[i] <= par_din;
                    end else if (ser_en && ser_last) begin
                        off_q[i] <= {ser_din, sh_q};
                    end
                end
            end
        end
    endgenerate

    // Write sequence and serial assembly
    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n) begin
            wr_sel  <= OFF_EMPTY;
            bit_cnt <= '0;
            sh_q    <= '0;
        end else if (par_ld) begin
            wr_sel <= (wr_sel == OFF_EMPTY) ? OFF_FULL : OFF_EMPTY;
        end else if (ser_en) begin
            if (ser_last) begin
                wr_sel  <= (wr_sel == OFF_EMPTY) ? OFF_FULL : OFF_EMPTY;
                bit_cnt <= '0;
            end else begin
                sh_q[bit_cnt] <= ser_din;
                bit_cnt       <= bit_cnt + 1'b1;
            end
        end
    end

    // Readback sequence and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel <= OFF_EMPTY;
            cfg_q  <= '0;
        end else if (!prst_n) begin
            rd_sel <= OFF_EMPTY;
        end else if (cfg_rd) begin
            cfg_q  <= off_q[rd_sel];
            rd_sel <= (rd_sel == OFF_EMPTY) ? OFF_FULL : OFF_EMPTY;
        end
    end
endmodule

// File: rtl/flag_logic.sv
// Module flag_logic
// Derives half, almost-empty and almost-full from the level and offsets.
// The almost flags are direct or registered according to a mode bit
// captured during master reset. Assumes offsets are below DEPTH.
module flag_logic #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int OFFW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prst_n,
    input  logic            mode_sel,
    input  logic [LW-1:0]   level,
    input  logic [OFFW-1:0] ae_off,
    input  logic [OFFW-1:0] af_off,
    output logic            half,
    output logic            almost_empty,
    output logic            almost_full,
    output logic            async_q
);
    logic ae_now;
    logic af_now;
    logic ae_q;
    logic af_q;

    // Threshold comparisons on the present level
    always_comb begin
        ae_now = (level <= LW'(ae_off));
        af_now = ((LW'(DEPTH) - level) <= LW'(af_off));
        half   = (level > LW'(DEPTH / 2));
    end

    // Capture timing mode during master reset only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            async_q <= mode_sel;
        end
    end

    // Registered copies of the almost flags; the reset values match an empty FIFO
    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n) begin
            ae_q <= 1'b1;
            af_q <= 1'b0;
        end else begin
            ae_q <= ae_now;
            af_q <= af_now;
        end
    end

    // Select direct or registered almost flags
    always_comb begin
        almost_empty = async_q ? ae_now : ae_q;
        almost_full  = async_q ? af_now : af_q;
    end
endmodule

// File: rtl/thr_flag_unit.sv
// Module thr_flag_unit
// Top of the FIFO threshold flag unit: occupancy counter, offset registers
// and flag comparisons. Assumes DEPTH is a power of two, at least 4.
module thr_flag_unit #(
    parameter int DEPTH = 16,
    parameter int OFFW  = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prst_n,
    input  logic [2:0]      preset_sel,
    input  logic            mode_sel,
    input  logic            push,
    input  logic            pop,
    input  logic            par_ld,
    input  logic [OFFW-1:0] par_din,
    input  logic            ser_en,
    input  logic            ser_din,
    input  logic            cfg_rd,
    output logic [OFFW-1:0] cfg_q,
    output logic [LW-1:0]   level,
    output logic            full,
    output logic            empty,
    output logic            half,
    output logic            almost_empty,
    output logic            almost_full
);
    logic [OFFW-1:0] ae_off;
    logic [OFFW-1:0] af_off;
    logic            async_q;

    occ_counter #(.DEPTH(DEPTH), .LW(LW)) u_occ (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n),
        .push(push), .pop(pop),
        .level(level), .full(full), .empty(empty)
    );

    offset_regs #(.OFFW(OFFW)) u_off (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n),
        .preset_sel(preset_sel),
        .par_ld(par_ld), .par_din(par_din),
        .ser_en(ser_en), .ser_din(ser_din),
        .cfg_rd(cfg_rd),
        .ae_off(ae_off), .af_off(af_off), .cfg_q(cfg_q)
    );

    flag_logic #(.DEPTH(DEPTH), .LW(LW), .OFFW(OFFW)) u_flag (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n),
        .mode_sel(mode_sel), .level(level),
        .ae_off(ae_off), .af_off(af_off),
        .half(half), .almost_empty(almost_empty), .almost_full(almost_full),
        .async_q(async_q)
    );
endmodule

// File: rtl/thr_flag_chk.sv
// Module thr_flag_chk
// Property checker for thr_flag_unit, attached by bind below.
// Assumes synchronous active-low resets on clk.
module thr_flag_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prst_n,
    input logic          push,
    input logic          pop,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          half,
    input logic          almost_empty,
    input logic          almost_full,
    input logic          async_q
);
    // A refused push at full leaves the level alone
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        (full && push && !pop) |=> (level == $past(level)));

    // A lone accepted pop drops the level by one
    assert_pop_step_R1: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        (pop && !push && !empty) |=> (level == $past(level) - 1'b1));

    // Full and empty never coexist
    assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // Half-full implies data present
    assert_half_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        half |-> !empty);

    // In direct mode an empty FIFO is always almost empty
    assert_async_ae_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (async_q && empty) |-> almost_empty);

    // In direct mode a full FIFO is always almost full
    assert_async_af_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (async_q && full) |-> almost_full);

    // Partial reset empties the FIFO
    assert_partial_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> (level == '0));
endmodule

bind thr_flag_unit thr_flag_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .prst_n(prst_n),
    .push(push), .pop(pop), .level(level),
    .full(full), .empty(empty), .half(half),
    .almost_empty(almost_empty), .almost_full(almost_full),
    .async_q(async_q)
);

// File: tb/sim_thr_flag_unit.sv
// Bench for thr_flag_unit: sweeps every preset and both timing modes over a
// full fill/drain, then exercises parallel/serial loads, collisions,
// readback and partial reset against an arithmetic reference model.
module sim_thr_flag_unit;
    localparam int DP = 16;
    localparam int OW = 4;
    localparam int LWD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0, prst_n = 1'b1;
    logic [2:0] preset_sel = '0;
    logic mode_sel = 1'b0, push = 1'b0, pop = 1'b0;
    logic par_ld = 1'b0, ser_en = 1'b0, ser_din = 1'b0, cfg_rd = 1'b0;
    logic [OW-1:0] par_din = '0;
    logic [OW-1:0] cfg_q;
    logic [LWD-1:0] level;
    logic full, empty, half, almost_empty, almost_full;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state
    int m_cnt = 0, m_ae = 1, m_af = 1, m_wp = 0, m_rp = 0, m_bits = 0, m_sv = 0, m_rb = 0;
    bit m_async = 0, m_aeq = 1, m_afq = 0;

    always #5 clk = ~clk;

    thr_flag_unit #(.DEPTH(DP)) u0 (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .preset_sel(preset_sel),
        .mode_sel(mode_sel), .push(push), .pop(pop), .par_ld(par_ld),
        .par_din(par_din), .ser_en(ser_en), .ser_din(ser_din), .cfg_rd(cfg_rd),
        .cfg_q(cfg_q), .level(level), .full(full), .empty(empty), .half(half),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    // Reference model, advanced on each rising edge from the driven inputs
    always @(posedge clk) begin
        int v;
        bit ap, aq;
        if (!rst_n) begin
            m_cnt <= 0; m_ae <= (preset_sel + 1) % 16; m_af <= (2 * preset_sel + 1) % 16;
            m_async <= mode_sel; m_wp <= 0; m_rp <= 0; m_bits <= 0; m_sv <= 0;
            m_rb <= 0; m_aeq <= 1; m_afq <= 0;
        end else if (!prst_n) begin
            m_cnt <= 0; m_wp <= 0; m_rp <= 0; m_bits <= 0; m_sv <= 0;
            m_aeq <= 1; m_afq <= 0;
        end else begin
            ap = push && (m_cnt < DP);
            aq = pop && (m_cnt > 0);
            m_cnt <= m_cnt + (ap ? 1 : 0) - (aq ? 1 : 0);
            m_aeq <= (m_cnt <= m_ae);
            m_afq <= ((DP - m_cnt) <= m_af);
            if (par_ld) begin
                if (m_wp == 0) m_ae <= par_din; else m_af <= par_din;
                m_wp <= 1 - m_wp;
            end else if (ser_en) begin
                v = m_sv | (int'(ser_din) << m_bits);
                if (m_bits == OW - 1) begin
                    if (m_wp == 0) m_ae <= v; else m_af <= v;
                    m_wp <= 1 - m_wp; m_bits <= 0; m_sv <= 0;
                end else begin
                    m_sv <= v; m_bits <= m_bits + 1;
                end
            end
            if (cfg_rd) begin
                m_rb <= (m_rp == 0) ? m_ae : m_af;
                m_rp <= 1 - m_rp;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare every status output with the model
    task automatic check_flags();
        chk("R1 level", int'(level), m_cnt);
        chk("R2 full", int'(full), int'(m_cnt == DP));
        chk("R2 empty", int'(empty), int'(m_cnt == 0));
        chk("R3 half", int'(half), int'(m_cnt > DP / 2));
        chk("R4 almost_empty", int'(almost_empty),
            m_async ? int'(m_cnt <= m_ae) : int'(m_aeq));
        chk("R4 almost_full", int'(almost_full),
            m_async ? int'((DP - m_cnt) <= m_af) : int'(m_afq));
    endtask

    task automatic cyc(input bit p, input bit q);
        push = p; pop = q;
        tick();
        push = 0; pop = 0;
        check_flags();
    endtask

    task automatic mreset(input int k, input bit md);
        rst_n = 0; preset_sel = 3'(k); mode_sel = md;
        tick(); tick();
        rst_n = 1; preset_sel = 3'(k + 3); mode_sel = !md;   // R5: ignored now
        tick();
        check_flags();
    endtask

    task automatic readback(input string req, input int exp);
        cfg_rd = 1; tick(); cfg_rd = 0;
        chk(req, int'(cfg_q), exp);
    endtask

    task automatic pload(input int val);
        par_ld = 1; par_din = OW'(val); tick(); par_ld = 0;
        check_flags();
    endtask

    task automatic sbit(input bit b);
        ser_en = 1; ser_din = b; tick(); ser_en = 0;
    endtask

    task automatic sword(input int val);
        for (int i = 0; i < OW; i++) sbit(val[i]);
        check_flags();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R5, R2, R3, R4, R1, R9: every preset in both modes, full fill and drain
        for (int md = 0; md < 2; md++) begin
            for (int k = 0; k < 8; k++) begin
                mreset(k, md[0]);
                chk("R5 reset level", int'(level), 0);
                readback("R9 R5 preset empty offset", (k + 1) % 16);
                readback("R9 R5 preset full offset", (2 * k + 1) % 16);
                for (int n = 0; n < DP + 1; n++) cyc(1, 0);
                chk("R1 capped at DEPTH", int'(level), DP);
                cyc(1, 1);   // R1: at full only the pop is accepted
                chk("R1 full push+pop", int'(level), DP - 1);
                cyc(1, 0);
                for (int n = 0; n < DP + 1; n++) cyc(0, 1);
                chk("R1 floored at 0", int'(level), 0);
            end
        end

        // R1: simultaneous push and pop at every level on the way up
        mreset(2, 1);
        for (int n = 0; n < DP; n++) begin
            cyc(1, 1);
            chk("R1 push+pop unchanged", int'(level), (n == 0) ? 1 : n);
            if (n > 0) cyc(1, 0);
        end

        // R6: parallel load in direct mode, effective at once in the flags
        mreset(0, 1);
        pload(5);
        pload(3);
        readback("R6 R9 parallel empty offset", 5);
        readback("R6 R9 parallel full offset", 3);
        for (int n = 0; n < DP; n++) cyc(1, 0);
        for (int n = 0; n < DP; n++) cyc(0, 1);

        // R7: serial LSB-first load in registered mode
        mreset(7, 0);
        sword(6);
        sword(2);
        readback("R7 R9 serial empty offset", 6);
        readback("R7 R9 serial full offset", 2);
        for (int n = 0; n < DP; n++) cyc(1, 0);
        for (int n = 0; n < DP; n++) cyc(0, 1);

        // R8: parallel write and serial bit in the same cycle
        mreset(1, 1);
        sbit(1); sbit(1);
        par_ld = 1; par_din = 4'd9; ser_en = 1; ser_din = 1;
        tick();
        par_ld = 0; ser_en = 0;
        sbit(0); sbit(0);
        readback("R8 parallel wins into empty offset", 9);
        readback("R8 serial word completes full offset", 3);
        check_flags();

        // R10: partial reset keeps offsets, clears level and sequences
        for (int n = 0; n < 6; n++) cyc(1, 0);
        readback("R10 read sequence before partial reset", 9);
        sbit(1); sbit(0);
        prst_n = 0; tick(); prst_n = 1;
        check_flags();
        chk("R10 level cleared", int'(level), 0);
        readback("R10 offset kept, read sequence restarted", 9);
        readback("R10 full offset kept", 3);
        sword(10);
        readback("R10 write sequence and serial restarted", 10);
        readback("R10 full offset untouched", 3);
        for (int n = 0; n < DP; n++) cyc(1, 0);

        finish_run();
    end
endmodule